// File: doc/BRIEF.md
# Micro-Threaded Quadrant Column Scheduler

This block sits in front of a DRAM core whose array is split into four quadrants. Each quadrant has two properties. Its left or right position ties it to one half of the data bus. Its top or bottom position is chosen by the most significant bank bit. Column-read requests arrive one per cycle on a single request port. Each request carries a bank number, a column address, a requester tag and the data-bus half it wants. The block files each request into a four-entry queue for its quadrant.

Each data-bus half has its own scheduler. One half-bank fetch fills only half of a data slot, so consecutive column commands on a half must alternate between the top and bottom half-banks. When the half-bank whose turn it is has nothing queued, the scheduler leaves the slot idle rather than break the alternation, and counts that lost slot. The two halves run independently, so each can be served from a different bank in the same cycle. This gives a quarter of the usual minimum fetch, provided traffic spreads over all four quadrants.

The core is modelled as an array with a fixed read latency. Read data returns on the half that issued the command, in issue order, tagged with the requester tag.

Top module: `uthread_quad_sched`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `cmd_valid` and `rd_valid` are 0, both `stall_cnt` fields are 0, and `quad_ready` is 4'b1111.
- R2: A request is routed to quadrant {req_half, req_bank[MSB]}: index 0 is left-bottom, 1 is left-top, 2 is right-bottom and 3 is right-top. It is issued on data half `req_half` with `cmd_top` equal to the bank MSB and with bank, column and tag unchanged. Requests to one quadrant issue in arrival order.
- R3: Each quadrant queue holds 4 requests. `quad_ready[q]` is 1 exactly when queue q holds fewer than 4, and `req_ready` equals `quad_ready` of the target quadrant. A request offered while its quadrant is not ready is dropped and never issued.
- R4: After its first command since reset, a data half issues every command from the opposite vertical half-bank to its previous command (`cmd_top` toggles from issue to issue).
- R5: Before its first command, a data half may start from either vertical half-bank, whichever has a request queued (bottom if both). That first choice fixes the alternation phase.
- R6: In a cycle where a half issues nothing because the required half-bank is empty while the other one has a request queued, that half's `stall_cnt` increases by 1. An idle cycle with nothing queued on that half leaves it unchanged.
- R7: A request accepted into an empty, eligible queue at clock edge k produces `cmd_valid` after edge k+1.
- R8: A command shown on `cmd_valid` after edge k causes `rd_valid` after edge k+4 on the same half. That return carries `rd_id` equal to the command's tag and `rd_data` = zero-extended {bank, column}, inverted bitwise on the right half.
- R9: The halves are independent: a stalled left half does not stop the right half from issuing, and both halves may issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered this cycle |
| req_half | input | 1 | Data-bus half wanted: 0 left, 1 right |
| req_bank | input | BANK_W | Bank number; MSB selects top half-bank |
| req_col | input | COL_W | Column address |
| req_id | input | ID_W | Requester tag |
| req_ready | output | 1 | Target quadrant queue can accept |
| quad_ready | output | 4 | Per-quadrant queue not full |
| cmd_valid | output | 2 | Column command issued, per half |
| cmd_top | output | 2 | Command targets top half-bank, per half |
| cmd_bank | output | 2 x BANK_W | Command bank, per half |
| cmd_col | output | 2 x COL_W | Command column, per half |
| cmd_id | output | 2 x ID_W | Command tag, per half |
| rd_valid | output | 2 | Read data valid, per half |
| rd_id | output | 2 x ID_W | Returned tag, per half |
| rd_data | output | 2 x DATA_W | Returned data word, per half |
| stall_cnt | output | 2 x STALL_W | Alternation idle-slot count, per half (wraps) |

## Verification
The hardest state to reach from the ports is a full quadrant queue. The single request port feeds no faster than a half drains, so a queue fills only while its own half is stalled on alternation. The stimulus therefore issues one left-bottom request and then sends more left-bottom requests with no top traffic. The queue fills and a sixth offer gets dropped, while right-half requests are slipped in to show that the halves run independently. A cycle-accurate model in the bench follows every queue, alternation phase, stall count and return slot through an ordered sweep of all bank and half combinations and a long pseudo-random run.

// File: rtl/mts_pkg.sv
// Package: shared quadrant encoding for the micro-threaded scheduler.
// Assumes quadrant index = {data half, vertical half}.
package mts_pkg;

    typedef enum logic {
        VHALF_BOTTOM = 1'b0,
        VHALF_TOP    = 1'b1
    } vhalf_e;

    localparam int NUM_QUADS = 4;
    localparam int NUM_HALVES = 2;

    // Map a data half and vertical half to a quadrant index.
    function automatic logic [1:0] quad_of(input logic data_half, input logic vert_top);
        return {data_half, vert_top};
    endfunction

endpackage

// File: rtl/mts_req_fifo.sv
// Module: mts_req_fifo
// Per-quadrant request queue, first in first out.
// Assumes: caller never pushes when full nor pops when empty.
module mts_req_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         not_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign dout      = mem[rd_ptr];
    assign not_empty = (count != '0);
    assign not_full  = (count != FULL_CNT);

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> not_full);

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

endmodule

// File: rtl/mts_half_sched.sv
// Module: mts_half_sched
// Column-command scheduler for one data-bus half. Alternates strictly
// between bottom and top half-bank queues once the first command issued;
// leaves a slot idle (and counts it) when the due half-bank is empty but
// the other has work. Assumes queue heads are valid when *_valid is high.
module mts_half_sched #(
    parameter int BANK_W  = 3,
    parameter int COL_W   = 6,
    parameter int ID_W    = 4,
    parameter int STALL_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bot_valid,
    input  logic [ID_W+BANK_W+COL_W-1:0]   bot_entry,
    input  logic                           top_valid,
    input  logic [ID_W+BANK_W+COL_W-1:0]   top_entry,
    output logic                           pop_bot,
    output logic                           pop_top,
    output logic                           cmd_valid,
    output logic                           cmd_top,
    output logic [BANK_W-1:0]              cmd_bank,
    output logic [COL_W-1:0]               cmd_col,
    output logic [ID_W-1:0]                cmd_id,
    output logic [STALL_W-1:0]             stall_cnt
);
    import mts_pkg::*;

    localparam int ENT_W = ID_W + BANK_W + COL_W;

    logic             started;
    vhalf_e           last_vh;
    vhalf_e           want_vh;
    logic             issue;
    logic             stall_hit;
    logic [ENT_W-1:0] pick;

    // Choose which half-bank is due this cycle.
    always_comb begin
        if (started) begin
            want_vh = (last_vh == VHALF_TOP) ? VHALF_BOTTOM : VHALF_TOP;
        end else begin
            want_vh = bot_valid ? VHALF_BOTTOM : VHALF_TOP;
        end
    end

    // Issue decision, queue pops and stall detection.
    always_comb begin
        issue     = (want_vh == VHALF_TOP) ? top_valid : bot_valid;
        pick      = (want_vh == VHALF_TOP) ? top_entry : bot_entry;
        pop_top   = issue && (want_vh == VHALF_TOP);
        pop_bot   = issue && (want_vh == VHALF_BOTTOM);
        stall_hit = started && !issue &&
                    ((want_vh == VHALF_TOP) ? bot_valid : top_valid);
    end

    // Registered command output and alternation state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            last_vh   <= VHALF_BOTTOM;
            cmd_valid <= 1'b0;
            cmd_top   <= 1'b0;
            cmd_bank  <= '0;
            cmd_col   <= '0;
            cmd_id    <= '0;
        end else begin
            cmd_valid <= issue;
            if (issue) begin
                started  <= 1'b1;
                last_vh  <= want_vh;
                cmd_top  <= (want_vh == VHALF_TOP);
                cmd_id   <= pick[ENT_W-1 -: ID_W];
                cmd_bank <= pick[COL_W +: BANK_W];
                cmd_col  <= pick[COL_W-1:0];
            end
        end
    end

    // Idle-slot counter, wraps at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_cnt <= '0;
        end else if (stall_hit) begin
            stall_cnt <= stall_cnt + 1'b1;
        end
    end

    // Independent observer of the output command stream.
    logic obs_seen;
    logic obs_last_top;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obs_seen     <= 1'b0;
            obs_last_top <= 1'b0;
        end else if (cmd_valid) begin
            obs_seen     <= 1'b1;
            obs_last_top <= cmd_top;
        end
    end

    assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && obs_seen) |-> (cmd_top != obs_last_top));

    assert_stall_on_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_cnt != $past(stall_cnt)) |-> !cmd_valid);

    assert_bank_matches_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bank[BANK_W-1] == cmd_top));

endmodule

// File: rtl/mts_read_pipe.sv
// Module: mts_read_pipe
// Fixed-latency model of the DRAM core for one data half. The word read
// is the zero-extended {bank, column}, inverted on the right half.
// Assumes DATA_W >= BANK_W + COL_W.
module mts_read_pipe #(
    parameter int BANK_W = 3,
    parameter int COL_W  = 6,
    parameter int ID_W   = 4,
    parameter int DATA_W = 16,
    parameter int LAT    = 4,
    parameter bit HALF   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [ID_W-1:0]   cmd_id,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] SALT = HALF ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    localparam int OUT_W = $clog2(LAT + 2);

    logic              st_v [LAT];
    logic [ID_W-1:0]   st_id [LAT];
    logic [DATA_W-1:0] st_d [LAT];
    logic [DATA_W-1:0] word;

    // Array read: address pattern, salted per half.
    assign word = DATA_W'({cmd_bank, cmd_col}) ^ SALT;

    // First stage captures the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v[0]  <= 1'b0;
            st_id[0] <= '0;
            st_d[0]  <= '0;
        end else begin
            st_v[0]  <= cmd_valid;
            st_id[0] <= cmd_id;
            st_d[0]  <= word;
        end
    end

    genvar s;
    generate
        for (s = 1; s < LAT; s++) begin : g_stage
            // Delay stage s of the core latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_v[s]  <= 1'b0;
                    st_id[s] <= '0;
                    st_d[s]  <= '0;
                end else begin
                    st_v[s]  <= st_v[s-1];
                    st_id[s] <= st_id[s-1];
                    st_d[s]  <= st_d[s-1];
                end
            end
        end
    endgenerate

    assign rd_valid = st_v[LAT-1];
    assign rd_id    = st_id[LAT-1];
    assign rd_data  = st_d[LAT-1];

    // Observer: commands in flight, issued minus returned.
    logic [OUT_W-1:0] in_flight;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= '0;
        end else begin
            in_flight <= in_flight + OUT_W'(cmd_valid) - OUT_W'(rd_valid);
        end
    end

    assert_return_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= OUT_W'(LAT));

    assert_return_has_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (in_flight != '0));

endmodule

// File: rtl/uthread_quad_sched.sv
// Module: uthread_quad_sched
// Top: steers column reads into four quadrant queues and runs one
// alternating scheduler and one fixed-latency core model per data half.
// Assumes at most one request per cycle; the MSB of the bank picks top.
module uthread_quad_sched #(
    parameter int NUM_BANKS  = 8,
    parameter int COL_W      = 6,
    parameter int ID_W       = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int RD_LAT     = 4,
    parameter int DATA_W     = 16,
    parameter int STALL_W    = 16,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_half,
    input  logic [BANK_W-1:0]            req_bank,
    input  logic [COL_W-1:0]             req_col,
    input  logic [ID_W-1:0]              req_id,
    output logic                         req_ready,
    output logic [3:0]                   quad_ready,
    output logic [1:0]                   cmd_valid,
    output logic [1:0]                   cmd_top,
    output logic [1:0][BANK_W-1:0]       cmd_bank,
    output logic [1:0][COL_W-1:0]        cmd_col,
    output logic [1:0][ID_W-1:0]         cmd_id,
    output logic [1:0]                   rd_valid,
    output logic [1:0][ID_W-1:0]         rd_id,
    output logic [1:0][DATA_W-1:0]       rd_data,
    output logic [1:0][STALL_W-1:0]      stall_cnt
);
    import mts_pkg::*;

    localparam int ENT_W = ID_W + BANK_W + COL_W;

    logic [1:0]       tgt_q;
    logic [ENT_W-1:0] req_entry;
    logic [3:0]       q_push;
    logic [3:0]       q_pop;
    logic [3:0]       q_ne;
    logic [3:0]       q_nf;
    logic [ENT_W-1:0] q_head [NUM_QUADS];
    logic [1:0]       pop_bot;
    logic [1:0]       pop_top;

    // Steering: quadrant from data half and bank MSB.
    always_comb begin
        tgt_q     = quad_of(req_half, req_bank[BANK_W-1]);
        req_entry = {req_id, req_bank, req_col};
        req_ready = q_nf[tgt_q];
    end

    assign quad_ready = q_nf;

    genvar q;
    generate
        for (q = 0; q < NUM_QUADS; q++) begin : g_quad
            assign q_push[q] = req_valid && req_ready && (tgt_q == 2'(q));
            assign q_pop[q]  = (q % 2 == 1) ? pop_top[q/2] : pop_bot[q/2];

            mts_req_fifo #(
                .W     (ENT_W),
                .DEPTH (FIFO_DEPTH)
            ) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[q]),
                .din       (req_entry),
                .pop       (q_pop[q]),
                .dout      (q_head[q]),
                .not_empty (q_ne[q]),
                .not_full  (q_nf[q])
            );
        end
    endgenerate

    genvar h;
    generate
        for (h = 0; h < NUM_HALVES; h++) begin : g_half
            mts_half_sched #(
                .BANK_W  (BANK_W),
                .COL_W   (COL_W),
                .ID_W    (ID_W),
                .STALL_W (STALL_W)
            ) u_sched (
                .clk       (clk),
                .rst_n     (rst_n),
                .bot_valid (q_ne[2*h]),
                .bot_entry (q_head[2*h]),
                .top_valid (q_ne[2*h+1]),
                .top_entry (q_head[2*h+1]),
                .pop_bot   (pop_bot[h]),
                .pop_top   (pop_top[h]),
                .cmd_valid (cmd_valid[h]),
                .cmd_top   (cmd_top[h]),
                .cmd_bank  (cmd_bank[h]),
                .cmd_col   (cmd_col[h]),
                .cmd_id    (cmd_id[h]),
                .stall_cnt (stall_cnt[h])
            );

            mts_read_pipe #(
                .BANK_W (BANK_W),
                .COL_W  (COL_W),
                .ID_W   (ID_W),
                .DATA_W (DATA_W),
                .LAT    (RD_LAT),
                .HALF   (h == 1)
            ) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .cmd_valid (cmd_valid[h]),
                .cmd_bank  (cmd_bank[h]),
                .cmd_col   (cmd_col[h]),
                .cmd_id    (cmd_id[h]),
                .rd_valid  (rd_valid[h]),
                .rd_id     (rd_id[h]),
                .rd_data   (rd_data[h])
            );
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (cmd_valid == 2'b00 && rd_valid == 2'b00));

    assert_pop_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q_pop[1:0]) <= 1 && $countones(q_pop[3:2]) <= 1);

endmodule

// File: tb/uthread_quad_sched_bench.sv
`timescale 1ns/1ps
module uthread_quad_sched_bench;
    localparam int NB = 8, CW = 6, IW = 4, DW = 16, SW = 16, BW = 3, LAT = 4, DEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_half = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [IW-1:0] req_id = '0;
    logic req_ready;
    logic [3:0] quad_ready;
    logic [1:0] cmd_valid, cmd_top, rd_valid;
    logic [1:0][BW-1:0] cmd_bank;
    logic [1:0][CW-1:0] cmd_col;
    logic [1:0][IW-1:0] cmd_id, rd_id;
    logic [1:0][DW-1:0] rd_data;
    logic [1:0][SW-1:0] stall_cnt;

    always #5 clk = ~clk;

    uthread_quad_sched u_uthread_quad_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_half(req_half),
        .req_bank(req_bank), .req_col(req_col), .req_id(req_id),
        .req_ready(req_ready), .quad_ready(quad_ready), .cmd_valid(cmd_valid),
        .cmd_top(cmd_top), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_id(cmd_id),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_data(rd_data), .stall_cnt(stall_cnt)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // Reference model state.
    int mq_bank [4][DEP], mq_col [4][DEP], mq_id [4][DEP], mq_cnt [4];
    bit m_started [2], m_last [2];
    bit e_cv [2], e_top [2];
    int e_bank [2], e_col [2], e_id [2], e_stall [2];
    bit p_v [2][LAT];
    int p_id [2][LAT], p_d [2][LAT];
    int issues_seen [4];
    int rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int q = 0; q < 4; q++) mq_cnt[q] = 0;
        for (int h = 0; h < 2; h++) begin
            m_started[h] = 0; m_last[h] = 0; e_cv[h] = 0; e_top[h] = 0;
            e_bank[h] = 0; e_col[h] = 0; e_id[h] = 0; e_stall[h] = 0;
            for (int s = 0; s < LAT; s++) begin p_v[h][s] = 0; p_id[h][s] = 0; p_d[h][s] = 0; end
        end
    endtask

    function automatic int core_word(input int h, input int b, input int c);
        int w = (b << CW) | c;
        return h ? (w ^ 32'hFFFF) : w;
    endfunction

    // Advance model by one clock edge with the inputs that were applied.
    task automatic model_edge(input bit v, input int hf, input int b, input int c, input int id);
        int tq;
        bit acc;
        tq = hf * 2 + ((b >> (BW - 1)) & 1);
        acc = v && (mq_cnt[tq] < DEP);
        for (int h = 0; h < 2; h++) begin
            for (int s = LAT - 1; s > 0; s--) begin
                p_v[h][s] = p_v[h][s-1]; p_id[h][s] = p_id[h][s-1]; p_d[h][s] = p_d[h][s-1];
            end
            p_v[h][0] = e_cv[h]; p_id[h][0] = e_id[h]; p_d[h][0] = core_word(h, e_bank[h], e_col[h]);
        end
        for (int h = 0; h < 2; h++) begin
            bit want, iss;
            int sq, oq;
            want = m_started[h] ? !m_last[h] : (mq_cnt[2*h] == 0);
            sq = 2 * h + int'(want);
            oq = 2 * h + int'(!want);
            iss = mq_cnt[sq] > 0;
            if (m_started[h] && !iss && mq_cnt[oq] > 0) e_stall[h] = (e_stall[h] + 1) & 32'hFFFF;
            e_cv[h] = iss;
            if (iss) begin
                e_top[h] = want; e_bank[h] = mq_bank[sq][0]; e_col[h] = mq_col[sq][0]; e_id[h] = mq_id[sq][0];
                for (int k = 0; k < DEP - 1; k++) begin
                    mq_bank[sq][k] = mq_bank[sq][k+1]; mq_col[sq][k] = mq_col[sq][k+1]; mq_id[sq][k] = mq_id[sq][k+1];
                end
                mq_cnt[sq]--;
                m_started[h] = 1; m_last[h] = want;
                issues_seen[sq]++;
            end
        end
        if (acc) begin
            mq_bank[tq][mq_cnt[tq]] = b; mq_col[tq][mq_cnt[tq]] = c; mq_id[tq][mq_cnt[tq]] = id;
            mq_cnt[tq]++;
        end
    endtask

    task automatic compare_outputs();
        for (int h = 0; h < 2; h++) begin
            chk(cmd_valid[h] == e_cv[h], "R4 cmd_valid", int'(cmd_valid[h]), int'(e_cv[h]));
            if (e_cv[h] && cmd_valid[h]) begin
                chk(cmd_top[h] == e_top[h], "R4 cmd_top", int'(cmd_top[h]), int'(e_top[h]));
                chk(int'(cmd_bank[h]) == e_bank[h], "R2 cmd_bank", int'(cmd_bank[h]), e_bank[h]);
                chk(int'(cmd_col[h]) == e_col[h], "R2 cmd_col", int'(cmd_col[h]), e_col[h]);
                chk(int'(cmd_id[h]) == e_id[h], "R2 cmd_id", int'(cmd_id[h]), e_id[h]);
            end
            chk(int'(stall_cnt[h]) == e_stall[h], "R6 stall_cnt", int'(stall_cnt[h]), e_stall[h]);
            chk(rd_valid[h] == p_v[h][LAT-1], "R8 rd_valid", int'(rd_valid[h]), int'(p_v[h][LAT-1]));
            if (p_v[h][LAT-1] && rd_valid[h]) begin
                chk(int'(rd_id[h]) == p_id[h][LAT-1], "R8 rd_id", int'(rd_id[h]), p_id[h][LAT-1]);
                chk(int'(rd_data[h]) == p_d[h][LAT-1], "R8 rd_data", int'(rd_data[h]), p_d[h][LAT-1]);
            end
        end
    endtask

    // One cycle: drive at negedge, check ready, let an edge pass, compare.
    task automatic tick(input bit v, input int hf, input int b, input int c, input int id);
        int tq;
        req_valid = v; req_half = hf[0]; req_bank = BW'(b); req_col = CW'(c); req_id = IW'(id);
        #1;
        for (int q = 0; q < 4; q++)
            chk(quad_ready[q] == (mq_cnt[q] < DEP), "R3 quad_ready", int'(quad_ready[q]), int'(mq_cnt[q] < DEP));
        tq = hf * 2 + ((b >> (BW - 1)) & 1);
        if (v) chk(req_ready == (mq_cnt[tq] < DEP), "R3 req_ready", int'(req_ready), int'(mq_cnt[tq] < DEP));
        @(posedge clk);
        @(negedge clk);
        model_edge(v, hf, b, c, id);
        compare_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_valid == 2'b00 && rd_valid == 2'b00, "R1 quiet in reset", int'({cmd_valid, rd_valid}), 0);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk(quad_ready == 4'hF, "R1 quad_ready", int'(quad_ready), 15);
        chk(stall_cnt[0] == '0 && stall_cnt[1] == '0, "R1 stall zero", int'(stall_cnt[0]) + int'(stall_cnt[1]), 0);
        chk(cmd_valid == 2'b00 && rd_valid == 2'b00, "R1 quiet after reset", int'({cmd_valid, rd_valid}), 0);
        @(negedge clk);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int rs;
        int b_ord [8] = '{0, 4, 1, 5, 2, 6, 3, 7};
        int right_iss;
        for (int q = 0; q < 4; q++) issues_seen[q] = 0;
        model_reset();
        @(negedge clk);
        do_reset();

        // R6: idle cycles with nothing queued leave the counters untouched.
        idle(20);
        chk(stall_cnt[0] == '0 && stall_cnt[1] == '0, "R6 idle no count", int'(stall_cnt[0]), 0);

        // R7: accept into empty queue, command one edge later.
        tick(1, 0, 0, 5, 1);
        chk(cmd_valid[0] == 1'b0, "R7 not yet issued", int'(cmd_valid[0]), 0);
        tick(0, 0, 0, 0, 0);
        chk(cmd_valid[0] == 1'b1, "R7 issued", int'(cmd_valid[0]), 1);
        idle(6);

        // R2 steering sweep: every half and bank, alternating vertical halves.
        for (int hf = 0; hf < 2; hf++)
            for (int ci = 0; ci < 4; ci++)
                for (int k = 0; k < 8; k++) begin
                    tick(1, hf, b_ord[(k + 1) % 8], (ci * 21 + k) % 64, (k + ci) % 16);
                    tick(0, 0, 0, 0, 0);
                end
        idle(8);

        // R5: first command may start on top; phase then alternates.
        do_reset();
        tick(1, 0, 6, 9, 3);
        tick(0, 0, 0, 0, 0);
        chk(cmd_valid[0] && cmd_top[0], "R5 first issue top", int'(cmd_top[0]), 1);
        tick(1, 0, 5, 10, 4);
        tick(1, 0, 2, 11, 5);
        tick(0, 0, 0, 0, 0);
        chk(cmd_valid[0] && !cmd_top[0], "R5 phase then bottom", int'(cmd_top[0]), 0);
        idle(8);

        // R3/R6/R9: stall left half on bottom-only traffic until queue fills.
        do_reset();
        for (int q = 0; q < 4; q++) issues_seen[q] = 0;
        for (int i = 0; i < 5; i++) tick(1, 0, 1, 40 + i, i);
        chk(quad_ready[0] == 1'b0, "R3 queue full", int'(quad_ready[0]), 0);
        tick(1, 0, 2, 63, 15);
        right_iss = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1, 1, (i % 2) ? 7 : 3, i, 8 + i);
            right_iss += int'(cmd_valid[1]);
        end
        chk(right_iss > 0, "R9 right issues while left stalled", right_iss, 1);
        chk(stall_cnt[0] > 0, "R6 stall counted", int'(stall_cnt[0]), 1);
        for (int i = 0; i < 5; i++) tick(1, 0, 4 + i % 4, i, i);
        idle(12);
        chk(issues_seen[0] == 5, "R3 dropped request not issued", issues_seen[0], 5);

        // Pseudo-random mixed traffic over all quadrants.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            rng = rng * 1103515245 + 12345;
            rs = (rng >>> 8) & 32'hFFFFFF;
            tick((rs % 10) < 7, (rs >> 4) & 1, (rs >> 5) & 7, (rs >> 8) & 63, (rs >> 14) & 15);
        end
        idle(12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule